// File: doc/BRIEF.md
# Debug Event Response Controller

This block decides what a processor core does when one of two debug events fires: an interrupt-taken event, which comes from an interrupt being taken, and an instruction-completion event. The response depends on the active debug mode.

In the halting modes (external or wait), the core is asked to stop. In internal-only mode, the event either raises a debug interrupt at once or, when debug interrupts are disabled, is recorded as imprecise. An imprecise event raises its interrupt later, when the enable bit returns, but only if its status is still set then. In trace-only mode, the event is recorded and reported on the trace indication, and execution carries on.

Software reads the sticky status bits and clears them by writing ones to them. The debug interrupt request stays up until the interrupt logic acknowledges it, and it carries the return address that was captured when the request was first raised.

Top module: `debug_event_resp`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, all status bits, `stop_req`, `dbg_irq`, `trace_ind` and `dbg_ret_addr` read 0.
- R2: The interrupt-taken event happens only in a cycle where both `en_irq_evt` and `irq_taken` are 1. Without the event, `stat_irq` stays 0.
- R3: In a halting mode (`mode_ext` or `mode_wait` is 1), an event sets its status bit and `stop_req` one cycle later.
  - This takes priority over the internal-mode response: no `dbg_irq` is raised.
  - `stop_req` holds until a cycle with `clr_wr`=1 and no new event.
- R4: In internal-only mode (`mode_int`=1, no halting mode), an interrupt with `irq_critical`=1 never produces the interrupt-taken event.
- R5: In internal-only mode with `msr_de`=1, an event sets its status bit and raises `dbg_irq` one cycle later. `dbg_ret_addr` is then the `next_pc` value from the event cycle.
- R6: In internal-only mode with `msr_de`=0, an interrupt-taken event sets both `stat_irq` and `stat_imp`. No `dbg_irq` is raised.
- R7: In internal-only mode, a 0-to-1 change of `msr_de` raises `dbg_irq` if `stat_imp` and an event status bit are still set, taking `dbg_ret_addr` from `next_pc` in that cycle. If software has cleared the event status bits first, no interrupt is raised.
- R8: In trace-only mode (`mode_trace`=1, all other modes 0), the interrupt-taken event sets `stat_irq` and pulses `trace_ind` for exactly one cycle. It raises neither `stop_req` nor `dbg_irq`.
- R9: The instruction-completion event needs `en_cmp_evt` and `insn_done`. It is produced in the halting modes, or in internal-only mode while `msr_de`=1. It is never produced in internal-only mode with `msr_de`=0, nor in trace-only mode.
- R10: Status bits are sticky and are cleared by `clr_wr` with `clr_mask`: bit 0 clears `stat_irq`, bit 1 clears `stat_cmp` and bit 2 clears `stat_imp`. A clear and a set in the same cycle leave the bit set.
- R11: `dbg_irq` stays at 1 until `dbg_ack`. `dbg_ret_addr` is loaded only in the cycle where the request goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_irq_evt | input | 1 | Enable for the interrupt-taken event |
| en_cmp_evt | input | 1 | Enable for the instruction-completion event |
| mode_ext | input | 1 | External debug mode |
| mode_wait | input | 1 | Debug wait mode |
| mode_int | input | 1 | Internal debug mode |
| mode_trace | input | 1 | Trace mode |
| msr_de | input | 1 | Debug interrupt enable from machine state |
| irq_taken | input | 1 | Pulse: an interrupt is being taken |
| irq_critical | input | 1 | The taken interrupt is of the critical class |
| insn_done | input | 1 | Pulse: an instruction-completion match |
| next_pc | input | ADDR_W | Address of the next instruction to run |
| clr_wr | input | 1 | Software write-one-to-clear strobe |
| clr_mask | input | 3 | Status bits to clear |
| dbg_ack | input | 1 | Acknowledge of the debug interrupt |
| stat_irq | output | 1 | Interrupt-taken event status |
| stat_cmp | output | 1 | Instruction-completion event status |
| stat_imp | output | 1 | Imprecise event status |
| stop_req | output | 1 | Request to halt instruction processing |
| dbg_irq | output | 1 | Debug interrupt request |
| dbg_ret_addr | output | ADDR_W | Saved return address for the debug interrupt |
| trace_ind | output | 1 | One-cycle trace-interface indication |

## Verification
The assertions check these behaviours on every cycle:
- stickiness of the status bits;
- holding of the debug interrupt request until it is acknowledged, and a stable return address while it is held;
- a stop request rising only from a halting mode;
- critical interrupts never setting status in internal-only mode;
- the imprecise bit rising only while debug interrupts are disabled;
- the trace pulse arising only in trace-only mode.

Other behaviours can only be shown by the bench's scenarios:
- the full mode priority table, exercised by sweeping every combination of mode, enable, interrupt class and `msr_de` for both events;
- the deferred interrupt and its cancellation by a clear;
- set-over-clear resolution;
- release of the stop request.

// File: rtl/debug_event_resp.sv
module debug_event_resp #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_irq_evt,
  input  logic              en_cmp_evt,
  input  logic              mode_ext,
  input  logic              mode_wait,
  input  logic              mode_int,
  input  logic              mode_trace,
  input  logic              msr_de,
  input  logic              irq_taken,
  input  logic              irq_critical,
  input  logic              insn_done,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic              clr_wr,
  input  logic [2:0]        clr_mask,
  input  logic              dbg_ack,
  output logic              stat_irq,
  output logic              stat_cmp,
  output logic              stat_imp,
  output logic              stop_req,
  output logic              dbg_irq,
  output logic [ADDR_W-1:0] dbg_ret_addr,
  output logic              trace_ind
);

  logic halt_md, int_only, trace_only;
  assign halt_md    = mode_ext | mode_wait;
  assign int_only   = mode_int & ~halt_md;
  assign trace_only = mode_trace & ~halt_md & ~mode_int;

  logic irq_evt, cmp_evt, any_evt;
  assign irq_evt = en_irq_evt & irq_taken &
                   (halt_md | (int_only & ~irq_critical) | trace_only);
  assign cmp_evt = en_cmp_evt & insn_done & (halt_md | (int_only & msr_de));
  assign any_evt = irq_evt | cmp_evt;

  logic irq_keep, cmp_keep, imp_keep;
  assign irq_keep = stat_irq & ~(clr_wr & clr_mask[0]);
  assign cmp_keep = stat_cmp & ~(clr_wr & clr_mask[1]);
  assign imp_keep = stat_imp & ~(clr_wr & clr_mask[2]);

  logic de_q, deferred, precise, raise;
  assign deferred = int_only & msr_de & ~de_q & imp_keep & (irq_keep | cmp_keep);
  assign precise  = int_only & msr_de & any_evt;
  assign raise    = precise | deferred;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_irq     <= 1'b0;
      stat_cmp     <= 1'b0;
      stat_imp     <= 1'b0;
      stop_req     <= 1'b0;
      dbg_irq      <= 1'b0;
      dbg_ret_addr <= '0;
      trace_ind    <= 1'b0;
      de_q         <= 1'b0;
    end else begin
      de_q      <= msr_de;
      stat_irq  <= irq_keep | irq_evt;
      stat_cmp  <= cmp_keep | cmp_evt;
      stat_imp  <= imp_keep | (int_only & ~msr_de & any_evt);
      trace_ind <= trace_only & irq_evt;
      if (halt_md & any_evt) stop_req <= 1'b1;
      else if (clr_wr)       stop_req <= 1'b0;
      dbg_irq <= raise | (dbg_irq & ~dbg_ack);
      if (raise & ~dbg_irq) dbg_ret_addr <= next_pc;
    end
  end

  assert_stop_from_halt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req) |-> $past(mode_ext | mode_wait));

  assert_no_critical_evt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_taken & irq_critical & mode_int & ~mode_ext & ~mode_wait & ~stat_irq) |=> !stat_irq);

  assert_imp_needs_de_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_imp) |-> $past(~msr_de & mode_int));

  assert_trace_only_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trace_ind |-> $past(mode_trace & ~mode_int & ~mode_ext & ~mode_wait));

  assert_sticky_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_irq & ~(clr_wr & clr_mask[0])) |=> stat_irq);

  assert_irq_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_irq & ~dbg_ack) |=> dbg_irq);

  assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_irq & ~dbg_ack) |=> $stable(dbg_ret_addr));

endmodule

// File: tb/debug_event_resp_bench.sv
module debug_event_resp_bench;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_irq_evt = 0, en_cmp_evt = 0, mode_ext = 0, mode_wait = 0, mode_int = 0, mode_trace = 0;
  logic msr_de = 0, irq_taken = 0, irq_critical = 0, insn_done = 0, clr_wr = 0, dbg_ack = 0;
  logic [AW-1:0] next_pc = '0;
  logic [2:0] clr_mask = '0;
  logic stat_irq, stat_cmp, stat_imp, stop_req, dbg_irq, trace_ind;
  logic [AW-1:0] dbg_ret_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  debug_event_resp #(.ADDR_W(AW)) u_debug_event_resp (
    .clk, .rst_n, .en_irq_evt, .en_cmp_evt, .mode_ext, .mode_wait, .mode_int, .mode_trace,
    .msr_de, .irq_taken, .irq_critical, .insn_done, .next_pc, .clr_wr, .clr_mask, .dbg_ack,
    .stat_irq, .stat_cmp, .stat_imp, .stop_req, .dbg_irq, .dbg_ret_addr, .trace_ind);

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] outv();
    return {dbg_ret_addr, stat_irq, stat_cmp, stat_imp, stop_req, dbg_irq, trace_ind};
  endfunction

  task automatic do_reset();
    rst_n = 0;
    {en_irq_evt, en_cmp_evt, mode_ext, mode_wait, mode_int, mode_trace} = '0;
    {msr_de, irq_taken, irq_critical, insn_done, clr_wr, dbg_ack} = '0;
    clr_mask = '0; next_pc = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R1 reset outputs", outv(), 64'd0);
    @(negedge clk);
    check("R1 after release", outv(), 64'd0);

    // R2..R8: sweep of the interrupt-taken event
    for (int i = 0; i < 128; i++) begin
      logic h, io, to, ev;
      logic [AW-1:0] pc;
      do_reset();
      {mode_ext, mode_wait, mode_int, mode_trace, en_irq_evt, irq_critical, msr_de} = i[6:0];
      pc = AW'(16'h1000 + i * 4);
      next_pc = pc;
      irq_taken = 1;
      h  = mode_ext | mode_wait;
      io = mode_int & ~h;
      to = mode_trace & ~h & ~mode_int;
      ev = en_irq_evt & (h | (io & ~irq_critical) | to);
      @(negedge clk);
      irq_taken = 0;
      check("R2-sweep R3 R4 R5 R6 R8 irq event", outv(),
            {(ev & io & msr_de) ? pc : AW'(0), ev, 1'b0, ev & io & ~msr_de,
             ev & h, ev & io & msr_de, ev & to});
      @(negedge clk);
      check("R8 trace pulse one cycle", {63'd0, trace_ind}, 64'd0);
    end

    // R9: sweep of the instruction-completion event
    for (int i = 0; i < 64; i++) begin
      logic h, io, ev;
      do_reset();
      {mode_ext, mode_wait, mode_int, mode_trace, en_cmp_evt, msr_de} = i[5:0];
      next_pc = AW'(16'h2000 + i);
      insn_done = 1;
      h  = mode_ext | mode_wait;
      io = mode_int & ~h;
      ev = en_cmp_evt & (h | (io & msr_de));
      @(negedge clk);
      insn_done = 0;
      check("R9 completion event", outv(),
            {(ev & io) ? AW'(16'h2000 + i) : AW'(0), 1'b0, ev, 1'b0, ev & h, ev & io, 1'b0});
    end

    // R7 deferred interrupt
    do_reset();
    mode_int = 1; en_irq_evt = 1; next_pc = 16'h0300; irq_taken = 1;
    @(negedge clk); irq_taken = 0;
    check("R6 imprecise recorded", {62'd0, stat_imp, dbg_irq}, 64'h2);
    @(negedge clk);
    msr_de = 1; next_pc = 16'h0444;
    @(negedge clk);
    check("R7 deferred raise", {47'd0, dbg_ret_addr, dbg_irq}, {47'd0, 16'h0444, 1'b1});

    // R7 cancelled by clear
    do_reset();
    mode_int = 1; en_irq_evt = 1; irq_taken = 1;
    @(negedge clk); irq_taken = 0;
    clr_wr = 1; clr_mask = 3'b001;
    @(negedge clk); clr_wr = 0;
    msr_de = 1;
    @(negedge clk);
    check("R7 cleared no raise", {62'd0, stat_imp, dbg_irq}, 64'h2);

    // R10 set beats clear, then clear
    do_reset();
    mode_trace = 1; en_irq_evt = 1; irq_taken = 1; clr_wr = 1; clr_mask = 3'b111;
    @(negedge clk); irq_taken = 0;
    check("R10 set wins over clear", {63'd0, stat_irq}, 64'd1);
    @(negedge clk); clr_wr = 0;
    check("R10 w1c clears", {63'd0, stat_irq}, 64'd0);

    // R11 hold and no reload
    do_reset();
    mode_int = 1; msr_de = 1; en_irq_evt = 1; next_pc = 16'h0A00; irq_taken = 1;
    @(negedge clk); next_pc = 16'h0B00;
    @(negedge clk); irq_taken = 0;
    check("R11 addr not reloaded", {47'd0, dbg_ret_addr, dbg_irq}, {47'd0, 16'h0A00, 1'b1});
    repeat (3) @(negedge clk);
    check("R11 held without ack", {63'd0, dbg_irq}, 64'd1);
    dbg_ack = 1;
    @(negedge clk); dbg_ack = 0;
    check("R11 dropped on ack", {63'd0, dbg_irq}, 64'd0);

    // R3 stop held until clear write
    do_reset();
    mode_wait = 1; en_irq_evt = 1; irq_taken = 1;
    @(negedge clk); irq_taken = 0;
    repeat (3) @(negedge clk);
    check("R3 stop held", {63'd0, stop_req}, 64'd1);
    clr_wr = 1; clr_mask = 3'b001;
    @(negedge clk); clr_wr = 0;
    check("R3 stop released", {62'd0, stop_req, stat_irq}, 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule